// File: doc/BRIEF.md
# Flash Erase Busy-Poll Sequencer

This block erases one sector of a serial NOR flash and waits for the erase to finish, without help from software. It takes a single start pulse with a 24-bit sector address. It then runs three kinds of single-line SPI frames on its own: first a write-enable, then the sector erase, then a series of read-status frames. It stops when the status byte matches a programmable mask and value. After that it shows either a done flag or an error flag.

Every frame is sent MSB-first in SPI mode 0 (clock idles low, data is sampled on the rising edge), and chip select is released between frames. A programmable idle gap separates the status reads. A programmable poll limit stops the sequencer from waiting forever on a device that never leaves the busy state. The addressing, the mask, the match value, the gap and the limit are captured when the start pulse is accepted. The host issues one request per erase and reads back two flags.

Top module: `nor_erase_poller`

## Requirements
- R1: After a synchronous active-low reset, `cs_n_o` is 1, `sck_o` is 0, and both `done_o` and `error_o` are 0.
- R2: A start accepted while idle first produces a chip-select frame of exactly 8 clocks carrying the write-enable code 0x06.
- R3: The second frame has exactly 32 clocks: the erase code (parameter, default 0x20) followed by the 24-bit address captured at start, most significant bit first, with no data or dummy clocks.
- R4: Each status frame has exactly 16 clocks. It sends the read-status code 0x05 during the first 8 clocks. During the last 8 clocks it samples `miso_i` on each rising clock edge as the status byte, MSB first.
- R5: A status byte S matches when (S AND mask) equals match. Polling stops after the first matching frame, and `done_o` rises while `error_o` stays 0.
- R6: Between two status frames, chip select stays high for at least G and at most G+4 system clocks, where G = gap × 2 × HALF_CYC (gap counts serial clock periods).
- R7: If `poll_limit_i` status frames in a row fail to match, no further frame is sent and `error_o` rises while `done_o` stays 0. A limit of 0 behaves as 1.
- R8: A start pulse that arrives while a sequence is running has no effect: the running sequence keeps its captured address and settings, and no new sequence follows it.
- R9: `sck_o` is low whenever `cs_n_o` is high. `mosi_o` never changes while `sck_o` is high inside a frame. Chip select is high for at least one system clock between any two frames.
- R10: `done_o` and `error_o` hold their value while idle, and both clear when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an erase sequence |
| addr_i | input | ADDR_W (24) | Sector address sent in the erase frame |
| stat_mask_i | input | 8 | Bits of the status byte that take part in the match |
| stat_match_i | input | 8 | Value the masked status byte must equal |
| poll_gap_i | input | GAP_W (8) | Idle serial clock periods between status frames |
| poll_limit_i | input | LIM_W (16) | Maximum number of status frames before an error |
| done_o | output | 1 | Erase finished: the status byte matched |
| error_o | output | 1 | Poll limit reached without a match |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
The hardest state to reach from the ports is the moment the poll limit and the device's ready point meet. In this state the last permitted status read is exactly the first one that reports ready, so one poll decides between done and error. The bench's flash model stays busy for a chosen number of status reads. The bench sweeps that count against every small poll limit, so it hits the "ready on the very last poll" and "ready one poll too late" boundaries directly. A second start pulse is injected while the sequencer is between status frames, which shows that a request during polling leaves the running erase unchanged.

// File: rtl/nfe_pkg.sv
// Shared constants and state types for the flash erase sequencer.
// Assumes a single-line SPI flash that uses the common 0x06 / 0x05 codes.
package nfe_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam int STATUS_FRAME_BITS = 16;

    typedef enum logic [2:0] {
        FR_IDLE, FR_SETUP, FR_HIGH, FR_LOW, FR_TAIL
    } fr_state_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_WREN_GO, SQ_WREN_RUN, SQ_ERASE_GO,
        SQ_ERASE_RUN, SQ_POLL_GO, SQ_POLL_RUN, SQ_GAP
    } sq_state_t;
endpackage

// File: rtl/nfe_spi_frame.sv
// Runs one SPI mode-0 frame: drops chip select, clocks nbits_i bits of
// tx_i out MSB-first, samples miso on every rising edge, then releases
// chip select. Each serial clock phase lasts HALF_CYC system clocks.
// Assumes go_i is only raised while the engine is idle and nbits_i > 0.
module nfe_spi_frame
    import nfe_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int FRAME_W  = 32,
    localparam int BITS_W  = $clog2(FRAME_W + 1),
    localparam int HC_W    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [BITS_W-1:0]  nbits_i,
    input  logic [FRAME_W-1:0] tx_i,
    output logic               fin_o,
    output logic [7:0]         rx_o,
    output logic               cs_n_o,
    output logic               sck_o,
    output logic               mosi_o,
    input  logic               miso_i
);
    fr_state_t          st;
    logic [HC_W-1:0]    hcnt;
    logic [FRAME_W-1:0] sreg;
    logic [BITS_W-1:0]  left;
    logic [7:0]         rx;
    logic               tick;

    assign tick   = (hcnt == HC_W'(HALF_CYC - 1));
    assign mosi_o = sreg[FRAME_W-1];
    assign fin_o  = (st == FR_TAIL) && tick;
    assign rx_o   = rx;

    // Phase timer: counts system clocks inside one serial clock half period.
    always_ff @(posedge clk) begin
        if (!rst_n || st == FR_IDLE || tick) hcnt <= '0;
        else                                 hcnt <= hcnt + 1'b1;
    end

    // Frame state machine: chip select, serial clock, shift and sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= FR_IDLE;
            cs_n_o <= 1'b1;
            sck_o  <= 1'b0;
            sreg   <= '0;
            left   <= '0;
            rx     <= '0;
        end else begin
            case (st)
                FR_IDLE: if (go_i) begin
                    cs_n_o <= 1'b0;
                    sreg   <= tx_i;
                    left   <= nbits_i;
                    st     <= FR_SETUP;
                end
                FR_SETUP, FR_LOW: if (tick) begin
                    sck_o <= 1'b1;
                    rx    <= {rx[6:0], miso_i};
                    st    <= FR_HIGH;
                end
                FR_HIGH: if (tick) begin
                    sck_o <= 1'b0;
                    sreg  <= sreg << 1;
                    left  <= left - 1'b1;
                    st    <= (left == BITS_W'(1)) ? FR_TAIL : FR_LOW;
                end
                FR_TAIL: if (tick) begin
                    cs_n_o <= 1'b1;
                    st     <= FR_IDLE;
                end
                default: st <= FR_IDLE;
            endcase
        end
    end

    // R9
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);
    // R9
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));
    // R4
    tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> !sck_o);
endmodule

// File: rtl/nfe_status_match.sv
// Decides whether a status byte reports the device as ready:
// the byte ANDed with the mask must equal the match value.
// Assumes mask and match are stable for the whole sequence.
module nfe_status_match #(
    parameter int ST_W = 8
) (
    input  logic [ST_W-1:0] status_i,
    input  logic [ST_W-1:0] mask_i,
    input  logic [ST_W-1:0] match_i,
    output logic            hit_o
);
    // AND-mode compare of the masked status against the expected value.
    always_comb hit_o = ((status_i & mask_i) == match_i);
endmodule

// File: rtl/nfe_poll_pacer.sv
// Keeps the idle gap timer between status frames and counts the
// status frames already issued against the poll limit.
// Assumes clear_i comes once at the start of each sequence.
module nfe_poll_pacer #(
    parameter int HALF_CYC = 2,
    parameter int GAP_W    = 8,
    parameter int LIM_W    = 16,
    localparam int TMR_W   = GAP_W + $clog2(2 * HALF_CYC) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_gap_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             gap_done_o,
    input  logic             poll_inc_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             last_poll_o
);
    logic [TMR_W-1:0] tmr;
    logic [LIM_W-1:0] pcnt;
    logic [LIM_W:0]   lim_eff;

    assign gap_done_o  = (tmr == '0);
    assign lim_eff     = (limit_i == '0) ? (LIM_W+1)'(1) : {1'b0, limit_i};
    assign last_poll_o = (({1'b0, pcnt} + 1'b1) >= lim_eff);

    // Gap timer: loads gap x one serial period in system clocks, counts down.
    always_ff @(posedge clk) begin
        if (!rst_n)          tmr <= '0;
        else if (load_gap_i) tmr <= TMR_W'(gap_i) * TMR_W'(2 * HALF_CYC);
        else if (tmr != '0)  tmr <= tmr - 1'b1;
    end

    // Poll counter: number of status frames finished in this sequence.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) pcnt <= '0;
        else if (poll_inc_i)   pcnt <= pcnt + 1'b1;
    end

    // R7
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, pcnt} <= lim_eff));
endmodule

// File: rtl/nor_erase_poller.sv
// Top of the flash erase sequencer. On an accepted start it sends
// write-enable, then the sector erase, then status reads separated by a
// programmable gap until the status matches (done) or the limit is hit
// (error). Assumes the host holds its inputs only for the start cycle.
module nor_erase_poller
    import nfe_pkg::*;
#(
    parameter int ADDR_W          = 24,
    parameter int HALF_CYC        = 2,
    parameter int GAP_W           = 8,
    parameter int LIM_W           = 16,
    parameter logic [7:0] ERASE_OP = 8'h20,
    localparam int FRAME_W        = 8 + ADDR_W,
    localparam int BITS_W         = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        stat_mask_i,
    input  logic [7:0]        stat_match_i,
    input  logic [GAP_W-1:0]  poll_gap_i,
    input  logic [LIM_W-1:0]  poll_limit_i,
    output logic              done_o,
    output logic              error_o,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    sq_state_t          st;
    logic [ADDR_W-1:0]  addr_q;
    logic [7:0]         mask_q, match_q;
    logic [GAP_W-1:0]   gap_q;
    logic [LIM_W-1:0]   limit_q;
    logic               go, fin, hit, gap_done, last_poll;
    logic               accept, poll_fin;
    logic [FRAME_W-1:0] tx;
    logic [BITS_W-1:0]  nbits;
    logic [7:0]         rx;

    assign accept   = (st == SQ_IDLE) && start_i;
    assign poll_fin = (st == SQ_POLL_RUN) && fin;

    // Frame selection: content and length for the frame being launched.
    always_comb begin
        go    = 1'b0;
        tx    = {OP_RDSR, {ADDR_W{1'b0}}};
        nbits = BITS_W'(STATUS_FRAME_BITS);
        case (st)
            SQ_WREN_GO: begin
                go    = 1'b1;
                tx    = {OP_WREN, {ADDR_W{1'b0}}};
                nbits = BITS_W'(8);
            end
            SQ_ERASE_GO: begin
                go    = 1'b1;
                tx    = {ERASE_OP, addr_q};
                nbits = BITS_W'(FRAME_W);
            end
            SQ_POLL_GO: go = 1'b1;
            default: ;
        endcase
    end

    nfe_spi_frame #(.HALF_CYC(HALF_CYC), .FRAME_W(FRAME_W)) frame_i (
        .clk(clk), .rst_n(rst_n), .go_i(go), .nbits_i(nbits), .tx_i(tx),
        .fin_o(fin), .rx_o(rx), .cs_n_o(cs_n_o), .sck_o(sck_o),
        .mosi_o(mosi_o), .miso_i(miso_i)
    );

    nfe_status_match #(.ST_W(8)) match_i (
        .status_i(rx), .mask_i(mask_q), .match_i(match_q), .hit_o(hit)
    );

    nfe_poll_pacer #(.HALF_CYC(HALF_CYC), .GAP_W(GAP_W), .LIM_W(LIM_W)) pacer_i (
        .clk(clk), .rst_n(rst_n), .clear_i(accept),
        .load_gap_i(poll_fin && !hit && !last_poll), .gap_i(gap_q),
        .gap_done_o(gap_done), .poll_inc_i(poll_fin),
        .limit_i(limit_q), .last_poll_o(last_poll)
    );

    // Request capture: settings are latched only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mask_q  <= '0;
            match_q <= '0;
            gap_q   <= '0;
            limit_q <= '0;
        end else if (accept) begin
            addr_q  <= addr_i;
            mask_q  <= stat_mask_i;
            match_q <= stat_match_i;
            gap_q   <= poll_gap_i;
            limit_q <= poll_limit_i;
        end
    end

    // Sequence state machine and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SQ_IDLE;
            done_o  <= 1'b0;
            error_o <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: if (start_i) begin
                    done_o  <= 1'b0;
                    error_o <= 1'b0;
                    st      <= SQ_WREN_GO;
                end
                SQ_WREN_GO:   st <= SQ_WREN_RUN;
                SQ_WREN_RUN:  if (fin) st <= SQ_ERASE_GO;
                SQ_ERASE_GO:  st <= SQ_ERASE_RUN;
                SQ_ERASE_RUN: if (fin) st <= SQ_POLL_GO;
                SQ_POLL_GO:   st <= SQ_POLL_RUN;
                SQ_POLL_RUN: if (fin) begin
                    if (hit) begin
                        done_o <= 1'b1;
                        st     <= SQ_IDLE;
                    end else if (last_poll) begin
                        error_o <= 1'b1;
                        st      <= SQ_IDLE;
                    end else begin
                        st <= SQ_GAP;
                    end
                end
                SQ_GAP: if (gap_done) st <= SQ_POLL_GO;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != SQ_IDLE && start_i) |=> $stable(addr_q));
    // R5
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));
    // R6
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_GAP) |-> cs_n_o);
    // R7
    err_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> $past(last_poll));
    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_IDLE && !start_i && done_o) |=> done_o);
endmodule

// File: tb/nor_erase_poller_tb_top.sv
module nor_erase_poller_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic [7:0]  stat_mask_i = '0, stat_match_i = '0;
    logic [7:0]  poll_gap_i = '0;
    logic [15:0] poll_limit_i = '0;
    logic        done_o, error_o, cs_n_o, sck_o, mosi_o;
    logic        miso_i = 1'b0;

    int checks = 0, failures = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_erase_poller #(.HALF_CYC(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .stat_mask_i(stat_mask_i), .stat_match_i(stat_match_i),
        .poll_gap_i(poll_gap_i), .poll_limit_i(poll_limit_i),
        .done_o(done_o), .error_o(error_o), .cs_n_o(cs_n_o),
        .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i)
    );

    // ---------------- flash model ----------------
    bit          model_on = 0;
    int          mbits = 0, nfr = 0, busy_left = 0, hcnt = 0, viol = 0;
    logic [31:0] mshift = '0;
    logic [7:0]  st_busy = 8'h03, st_ready = 8'h02, cur_st = '0;
    int          fbits [0:255];
    logic [31:0] fword [0:255];
    int          gapv  [0:255];
    logic        prev_sck = 0, prev_mosi = 0;

    always @(negedge cs_n_o) if (model_on) begin
        mbits  = 0;
        mshift = '0;
        cur_st = (busy_left > 0) ? st_busy : st_ready;
    end
    always @(posedge sck_o) if (model_on && !cs_n_o) begin
        mshift = {mshift[30:0], mosi_o};
        mbits++;
    end
    always @(negedge sck_o) if (model_on && !cs_n_o && mbits >= 8 && mbits < 16)
        miso_i = cur_st[15 - mbits];
    always @(posedge cs_n_o) if (model_on) begin
        if (nfr < 256) begin
            fbits[nfr] = mbits;
            fword[nfr] = mshift;
        end
        if (mbits == 16 && mshift[15:8] == 8'h05 && busy_left > 0) busy_left--;
        nfr++;
        miso_i = 1'b0;
    end

    // Bus monitor and watchdog, sampled away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (model_on) begin
            if (cs_n_o) hcnt++;
            else if (hcnt > 0) begin
                if (nfr < 256) gapv[nfr] = hcnt;
                hcnt = 0;
            end
            if (cs_n_o && sck_o) viol++;
            if (!cs_n_o && sck_o && prev_sck && mosi_o != prev_mosi) viol++;
        end
        prev_sck  = sck_o;
        prev_mosi = mosi_o;
        if (cyc > 190000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: act=%0d exp<190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Expected outcome computed from the match rule and the limit.
    task automatic predict(input int busy_n, input int lim, input logic [7:0] m,
                           input logic [7:0] t, output int polls, output bit ok);
        int l = (lim == 0) ? 1 : lim;
        polls = l;
        ok = 0;
        for (int k = 0; k < l; k++) begin
            logic [7:0] s = (k < busy_n) ? st_busy : st_ready;
            if ((s & m) == t) begin
                polls = k + 1;
                ok = 1;
                break;
            end
        end
    endtask

    task automatic run_seq(input logic [23:0] a, input logic [7:0] m,
                           input logic [7:0] t, input int gap, input int lim,
                           input int busy_n, input bit poke);
        int polls, g;
        bit ok;
        bit f_ok;
        predict(busy_n, lim, m, t, polls, ok);
        @(negedge clk);
        nfr = 0; hcnt = 0; busy_left = busy_n;
        addr_i = a; stat_mask_i = m; stat_match_i = t;
        poll_gap_i = 8'(gap); poll_limit_i = 16'(lim);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R10: the accepted start clears both flags
        check(!done_o && !error_o, "R10", "flags clear on start",
              {done_o, error_o}, 0);
        addr_i = ~a; stat_mask_i = 8'h00; stat_match_i = 8'h00; poll_limit_i = 16'd1;
        if (poke) begin
            while (nfr < 3 && cyc < 180000) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o && !error_o && cyc < 180000) @(negedge clk);
        repeat (80) @(negedge clk);
        // R2
        check(fbits[0] == 8 && fword[0][7:0] == 8'h06, "R2", "wren frame",
              {fbits[0], fword[0][7:0]}, {32'd8, 8'h06});
        // R3 (and R8 when poked: captured address kept)
        check(fbits[1] == 32 && fword[1] == {8'h20, a}, "R3", "erase frame",
              fword[1], {8'h20, a});
        f_ok = 1;
        for (int k = 2; k < 2 + polls && k < 256; k++)
            if (fbits[k] != 16 || fword[k][15:8] != 8'h05) f_ok = 0;
        // R4
        check(f_ok, "R4", "status frames", f_ok, 1);
        // R5 / R7 frame count, R8 no extra sequence
        check(nfr == 2 + polls, ok ? "R5" : "R7", "frame count", nfr, 2 + polls);
        check(done_o == ok && error_o == !ok, ok ? "R5" : "R7", "done/error",
              {done_o, error_o}, {ok, !ok});
        // R9 chip select released between frames
        check(gapv[1] >= 1 && gapv[2] >= 1, "R9", "cs high between frames",
              gapv[1], 1);
        g = gap * 2 * HALF;
        f_ok = 1;
        for (int k = 3; k < 2 + polls && k < 256; k++)
            if (gapv[k] < g || gapv[k] > g + 4) f_ok = 0;
        // R6
        check(f_ok, "R6", "poll gap", (polls > 1) ? gapv[3] : g, g);
        // R10 flags hold while idle
        check(done_o == ok && error_o == !ok, "R10", "flags held",
              {done_o, error_o}, {ok, !ok});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(cs_n_o == 1 && sck_o == 0 && done_o == 0 && error_o == 0, "R1",
              "reset state", {cs_n_o, sck_o, done_o, error_o}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1;
        // Sweep: busy count against poll limit, two gap settings.
        for (int gi = 0; gi < 2; gi++)
            for (int b = 0; b < 5; b++)
                for (int l = 1; l < 5; l++)
                    run_seq(24'hA50000 ^ 24'(b * 24'h013579 + l * 24'h000F11),
                            8'h01, 8'h00, gi * 3, l, b, 0);
        // R5: wider mask, bit 1 must be set and bit 0 clear
        run_seq(24'h123456, 8'h03, 8'h02, 1, 5, 2, 0);
        // R5: match on a high bit
        st_busy = 8'h01; st_ready = 8'h81;
        run_seq(24'hFEDCBA, 8'h80, 8'h80, 2, 3, 1, 0);
        st_busy = 8'h03; st_ready = 8'h02;
        // R7: a limit of 0 acts as 1
        run_seq(24'h000001, 8'h01, 8'h00, 0, 0, 2, 0);
        // R8: start pulse during polling is ignored
        run_seq(24'h5A5A5A, 8'h01, 8'h00, 6, 8, 3, 1);
        // R9 over the whole run
        check(viol == 0, "R9", "mode-0 bus rules", viol, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule